// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer activity into the five-byte frame a serial mouse sends, and holds the bytes in a circular receive queue. A host drains the queue one byte at a time through a data-read strobe. Each event strobe carries a signed horizontal step, a signed vertical step and three button flags. The encoder latches the event and writes the five frame bytes into the queue on five consecutive cycles. While it does this it raises `busy`, and any further strobe is dropped.

The frame begins with a header byte. In the header, a pressed button is shown as a cleared bit. The two motion bytes follow. Each is limited to the symmetric range −127..+127, and the vertical motion is sent with its sign flipped. Two zero bytes end the frame. The queue raises a receive-available level whenever it holds data. It also pulses an interrupt request whenever a byte is stored, and again when a read leaves data behind. A synchronous channel reset empties the queue and abandons any frame that is only partly written.

Top module: `mouse_pkt_enc`

## Requirements
- R1: The first byte of a frame is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared for the middle button and bit 0 cleared for the right button.
- R2: The second byte is the horizontal step, clamped to −127..+127 and written as 8-bit two's complement, so values above 127 give 0x7F and values below −127 give 0x81.
- R3: The third byte is the negated vertical step, clamped to −127..+127 in the same way.
- R4: The fourth and fifth bytes are 0x00. The encoder writes the five bytes one per cycle in frame order. The first byte is written on the clock edge that follows the edge accepting the strobe.
- R5: `busy` is high for exactly five cycles after an accepted strobe. A strobe that is sampled while `busy` is high has no effect.
- R6: The queue holds up to DEPTH bytes in arrival order. A byte that arrives when the queue already holds DEPTH bytes (counted before any read in the same cycle) is discarded.
- R7: `rd_data` shows the oldest queued byte, or 0x00 when the queue is empty. A cycle with `rd_pop` high removes that byte. `rd_pop` on an empty queue changes nothing.
- R8: `rx_avail` is high exactly when the queue holds at least one byte.
- R9: `rx_irq` is high for one cycle after each stored byte, and for one cycle after a read that leaves at least one byte in the queue.
- R10: A low `rst_n` or a high `chan_rst` at a clock edge empties the queue, ends any frame in progress and drops a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| evt_valid | input | 1 | Mouse event strobe |
| evt_dx | input | MW | Signed horizontal step |
| evt_dy | input | MW | Signed vertical step |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| busy | output | 1 | Frame being written into the queue |
| rd_pop | input | 1 | Host data read; removes the oldest byte |
| rd_data | output | 8 | Oldest queued byte, 0x00 when empty |
| rx_avail | output | 1 | Queue not empty |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
A wrong frame index or a stale latched event shows up as a wrong `rd_data` value when the host reads that byte. A wrong `busy` length shows up in the cycle where `busy` falls. A wrong queue pointer or count shows up at the next read: the byte comes out of order, or `rx_avail` is wrong on the very next clock. The interrupt pulse is checked every cycle, so a missing or extra pulse is reported at the edge that produced it.

// File: rtl/mpe_pkg.sv
// Shared constants and types for the mouse packet encoder.
// Assumes a fixed five-byte frame and 8-bit queue entries.
package mpe_pkg;
    typedef logic [7:0] byte_t;
    localparam int    PKT_BYTES = 5;
    localparam int    IDX_W     = $clog2(PKT_BYTES);
    localparam byte_t HDR_BASE  = 8'h87;
    localparam int    MOT_LIM   = 127;
endpackage

// File: rtl/mpe_motion_clamp.sv
// Turns a signed motion step into one frame byte.
// Optionally negates the step first, then clamps it to +/-MOT_LIM.
// Assumes W >= 8. The sign-extended intermediate keeps the negation of the most negative value exact.
module mpe_motion_clamp
    import mpe_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] step_in,
    input  logic                negate,
    output byte_t               step_byte
);
    localparam logic signed [W:0] POS_LIM = (W+1)'(MOT_LIM);
    localparam logic signed [W:0] NEG_LIM = -POS_LIM;

    logic signed [W:0] ext;

    // Widen the step, negate if needed, and clamp it to the byte range.
    always_comb begin
        ext = negate ? -{step_in[W-1], step_in} : {step_in[W-1], step_in};
        if (ext > POS_LIM)      step_byte = POS_LIM[7:0];
        else if (ext < NEG_LIM) step_byte = NEG_LIM[7:0];
        else                    step_byte = ext[7:0];
    end
endmodule

// File: rtl/mpe_pkt_seq.sv
// Frame sequencer. When idle it accepts a strobe and latches the five frame bytes.
// It then presents one byte per cycle for five cycles, with busy high the whole time.
// Assumes the downstream queue takes or drops each byte in its presentation cycle.
module mpe_pkt_seq
    import mpe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  start,
    input  byte_t hdr_byte,
    input  byte_t x_byte,
    input  byte_t y_byte,
    output logic  busy,
    output logic  push_vld,
    output byte_t push_data
);
    byte_t              frame [PKT_BYTES];
    logic [IDX_W-1:0]   idx;

    // Control: start on a strobe when idle, step the index, stop after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (busy) begin
            if (idx == IDX_W'(PKT_BYTES - 1)) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end
    end

    // Data: latch the frame contents on an accepted strobe. Trailing bytes are zero.
    always_ff @(posedge clk) begin
        if (!busy && start) begin
            frame[0] <= hdr_byte;
            frame[1] <= x_byte;
            frame[2] <= y_byte;
            for (int k = 3; k < PKT_BYTES; k++) frame[k] <= '0;
        end
    end

    assign push_vld  = busy;
    assign push_data = frame[idx];
endmodule

// File: rtl/mpe_byte_fifo.sv
// Circular byte queue with separate read and write pointers and an occupancy count.
// A push into a full queue is dropped, and a pop of an empty queue does nothing.
// Fullness is judged on the count before any same-cycle pop.
// Raises a one-cycle interrupt pulse after a stored byte, or after a pop that leaves data.
module mpe_byte_fifo
    import mpe_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  byte_t         wdata,
    input  logic          pop,
    output byte_t         rdata,
    output logic [CW-1:0] fill,
    output logic          irq_pulse
);
    byte_t          mem [DEPTH];
    logic [AW-1:0]  wptr, rptr;
    logic           push_ok, pop_ok;

    assign push_ok = push && (fill != CW'(DEPTH));
    assign pop_ok  = pop  && (fill != '0);
    assign rdata   = (fill != '0) ? mem[rptr] : '0;

    // Pointers, count and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr      <= '0;
            rptr      <= '0;
            fill      <= '0;
            irq_pulse <= 1'b0;
        end else begin
            if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            fill      <= fill + CW'(push_ok) - CW'(pop_ok);
            irq_pulse <= push_ok || (pop_ok && (fill > CW'(1)));
        end
    end

    // Storage write. The array has no reset; entries are read only when valid.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end
endmodule

// File: rtl/mouse_pkt_enc.sv
// Top of the serial mouse packet encoder.
// Builds the header and the clamped motion bytes, runs the frame sequencer and feeds the receive queue.
// Assumes MW >= 8. All inputs are synchronous to clk.
module mouse_pkt_enc
    import mpe_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int MW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_rst,
    input  logic          evt_valid,
    input  logic [MW-1:0] evt_dx,
    input  logic [MW-1:0] evt_dy,
    input  logic          btn_left,
    input  logic          btn_mid,
    input  logic          btn_right,
    output logic          busy,
    input  logic          rd_pop,
    output logic [7:0]    rd_data,
    output logic          rx_avail,
    output logic          rx_irq
);
    byte_t          hdr_byte;
    byte_t          axis_byte [2];
    logic           push_vld;
    byte_t          push_data;
    logic [CW-1:0]  fill_lvl;

    // Header: each pressed button clears its bit in the base value.
    always_comb hdr_byte = HDR_BASE & ~{5'b0, btn_left, btn_mid, btn_right};

    // One clamp per axis. The vertical axis (index 1) is negated.
    for (genvar a = 0; a < 2; a++) begin : g_axis
        mpe_motion_clamp #(.W(MW)) u_clamp (
            .step_in   ((a == 0) ? evt_dx : evt_dy),
            .negate    (a == 1),
            .step_byte (axis_byte[a])
        );
    end

    mpe_pkt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (chan_rst),
        .start     (evt_valid),
        .hdr_byte  (hdr_byte),
        .x_byte    (axis_byte[0]),
        .y_byte    (axis_byte[1]),
        .busy      (busy),
        .push_vld  (push_vld),
        .push_data (push_data)
    );

    mpe_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (chan_rst),
        .push      (push_vld),
        .wdata     (push_data),
        .pop       (rd_pop),
        .rdata     (rd_data),
        .fill      (fill_lvl),
        .irq_pulse (rx_irq)
    );

    assign rx_avail = (fill_lvl != '0);
endmodule

// File: rtl/mpe_checker.sv
// Property checker for mouse_pkt_enc, attached to it by the bind below.
// Counts busy cycles locally so that the frame length is checked without a long $past.
module mpe_checker #(
    parameter int DEPTH = 256,
    parameter int CW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chan_rst,
    input logic          evt_valid,
    input logic          busy,
    input logic [7:0]    rd_data,
    input logic          rx_avail,
    input logic          rx_irq,
    input logic [CW-1:0] fill
);
    logic [2:0] busy_cnt;

    // Counts consecutive busy cycles; cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) busy_cnt <= '0;
        else if (busy)          busy_cnt <= busy_cnt + 1'b1;
        else                    busy_cnt <= '0;
    end

    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !busy && !chan_rst) |=> busy);

    p_frame_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(chan_rst)) |-> (busy_cnt == 3'd5));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_avail |-> (rd_data == 8'h00));

    p_irq_has_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_avail);

    p_chan_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (!busy && !rx_avail && !rx_irq));
endmodule

bind mouse_pkt_enc mpe_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_rst  (chan_rst),
    .evt_valid (evt_valid),
    .busy      (busy),
    .rd_data   (rd_data),
    .rx_avail  (rx_avail),
    .rx_irq    (rx_irq),
    .fill      (fill_lvl)
);

// File: tb/sim_mouse_pkt_enc.sv
// Bench: a behavioural queue model is updated on every rising edge.
// All outputs are compared with it on every falling edge, and directed reads check known byte values.
module sim_mouse_pkt_enc;
    localparam int DEPTH = 16;
    localparam int MW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0, chan_rst = 1'b0, evt_valid = 1'b0, rd_pop = 1'b0;
    logic signed [MW-1:0] evt_dx = '0, evt_dy = '0;
    logic btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
    logic busy, rx_avail, rx_irq;
    logic [7:0] rd_data;

    int checks = 0, fails = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    mouse_pkt_enc #(.DEPTH(DEPTH), .MW(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .evt_valid(evt_valid),
        .evt_dx(evt_dx), .evt_dy(evt_dy), .btn_left(btn_left), .btn_mid(btn_mid),
        .btn_right(btn_right), .busy(busy), .rd_pop(rd_pop), .rd_data(rd_data),
        .rx_avail(rx_avail), .rx_irq(rx_irq)
    );

    // Reference model state
    byte unsigned q[$];
    byte unsigned pend[$];
    bit m_irq = 0;

    function automatic byte unsigned sat(int v);
        if (v > 127)  return 8'h7F;
        if (v < -127) return 8'h81;
        return v[7:0];
    endfunction

    always @(posedge clk) begin
        int cnt_before;
        bit was_busy, push_ok, pop_ok;
        byte unsigned b;
        started = 1;
        if (!rst_n || chan_rst) begin
            q.delete(); pend.delete(); m_irq = 0;
        end else begin
            cnt_before = q.size();
            was_busy = pend.size() != 0;
            push_ok = 0;
            pop_ok = rd_pop && cnt_before > 0;
            if (was_busy) begin
                b = pend.pop_front();
                push_ok = cnt_before < DEPTH;
            end
            if (pop_ok) void'(q.pop_front());
            if (push_ok) q.push_back(b);
            m_irq = push_ok || (pop_ok && cnt_before > 1);
            if (!was_busy && evt_valid) begin
                b = 8'h87;
                if (btn_left)  b[2] = 1'b0;
                if (btn_mid)   b[1] = 1'b0;
                if (btn_right) b[0] = 1'b0;
                pend.push_back(b);
                pend.push_back(sat(int'(evt_dx)));
                pend.push_back(sat(-int'(evt_dy)));
                pend.push_back(8'h00);
                pend.push_back(8'h00);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (started) begin
            chk("R5 busy", busy, pend.size() != 0);
            chk("R7 rd_data", rd_data, q.size() ? q[0] : 0);
            chk("R8 rx_avail", rx_avail, q.size() != 0);
            chk("R9 rx_irq", rx_irq, m_irq);
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(int dx, int dy, bit l, bit m, bit r);
        evt_dx = MW'(dx); evt_dy = MW'(dy);
        btn_left = l; btn_mid = m; btn_right = r;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic read_exp(string tag, int exp);
        chk(tag, rd_data, exp);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        // R10: reset state
        chk("R10 reset busy", busy, 0);
        chk("R10 reset rx_avail", rx_avail, 0);
        chk("R10 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 R2 R3 R4: clamp high x, small y, left button
        send(300, 5, 1, 0, 0);
        wait_cyc(6);
        read_exp("R1 header left", 8'h83);
        read_exp("R2 dx clamp high", 8'h7F);
        read_exp("R3 dy negated", 8'hFB);
        read_exp("R4 pad0", 8'h00);
        read_exp("R4 pad1", 8'h00);
        // R7: read of an empty queue
        read_exp("R7 empty read", 8'h00);
        chk("R7 empty avail", rx_avail, 0);

        // R1 R2 R3: middle and right buttons, negative clamps
        send(-500, -200, 0, 1, 1);
        wait_cyc(6);
        read_exp("R1 header mid+right", 8'h84);
        read_exp("R2 dx clamp low", 8'h81);
        read_exp("R3 dy negative clamps high", 8'h7F);
        read_exp("R4 pad0", 8'h00);
        read_exp("R4 pad1", 8'h00);

        // R2 R3: extreme and boundary values
        send(-32768, -32768, 0, 0, 0);
        wait_cyc(6);
        read_exp("R1 header none", 8'h87);
        read_exp("R2 dx most negative", 8'h81);
        read_exp("R3 dy most negative", 8'h7F);
        read_exp("R4 pad0", 8'h00);
        read_exp("R4 pad1", 8'h00);
        send(127, 127, 1, 1, 1);
        wait_cyc(6);
        read_exp("R1 header all", 8'h80);
        read_exp("R2 dx at limit", 8'h7F);
        read_exp("R3 dy at limit", 8'h81);
        read_exp("R4 pad0", 8'h00);
        read_exp("R4 pad1", 8'h00);

        // R5: second strobe while busy is ignored
        send(1, 1, 0, 0, 0);
        send(50, 50, 1, 0, 0);
        wait_cyc(6);
        read_exp("R5 only first frame hdr", 8'h87);
        read_exp("R5 only first frame x", 8'h01);
        read_exp("R5 only first frame y", 8'hFF);
        read_exp("R5 pad0", 8'h00);
        read_exp("R5 pad1", 8'h00);
        chk("R5 no second frame", rx_avail, 0);

        // R6: overflow of the queue
        for (int i = 0; i < 4; i++) begin
            send(i, 0, 0, 0, i == 3);
            wait_cyc(6);
        end
        for (int i = 0; i < 15; i++) read_exp("R6 drain", (i % 5 == 0) ? 8'h87 : (i % 5 == 1) ? i / 5 : 0);
        read_exp("R6 last kept byte", 8'h86);
        chk("R6 rest dropped", rx_avail, 0);

        // R10: channel reset mid-frame with a simultaneous strobe
        send(9, 9, 0, 0, 0);
        wait_cyc(1);
        chan_rst = 1'b1; evt_valid = 1'b1;
        @(negedge clk);
        chan_rst = 1'b0; evt_valid = 1'b0;
        chk("R10 flush busy", busy, 0);
        chk("R10 flush avail", rx_avail, 0);
        wait_cyc(6);
        chk("R10 no resumed frame", rx_avail, 0);

        // Random traffic, compared against the model every cycle
        for (int i = 0; i < 600; i++) begin
            evt_valid = ($urandom_range(0, 3) == 0);
            evt_dx = MW'(int'($urandom_range(0, 600)) - 300);
            evt_dy = MW'(int'($urandom_range(0, 600)) - 300);
            {btn_left, btn_mid, btn_right} = 3'($urandom_range(0, 7));
            rd_pop = ($urandom_range(0, 2) == 0);
            chan_rst = ($urandom_range(0, 150) == 0);
            @(negedge clk);
        end
        evt_valid = 1'b0; rd_pop = 1'b0; chan_rst = 1'b0;
        wait_cyc(8);
        summary();
    end
endmodule